// File: doc/BRIEF.md
# Dual-Mode Pixel Bus Capture

This block receives pixel data from a graphics controller port and delivers whole 24-bit pixels on the rising edge of the pixel clock. In narrow mode, the controller sends each pixel as two 12-bit halves, one on each clock edge. The block joins every pair into one word. In wide mode, the full 24-bit pixel arrives on a single selected edge. The horizontal sync, vertical sync and data-enable qualifiers travel with the pixel. They are taken from the half that starts each pixel.

The bus width, the latching edge and the clock-mode request come from one of two places: a set of strap pins or a set of control register fields. An interface-select input picks the source. Narrow mode always latches on both edges and wide mode always latches on one edge, so the two unsupported combinations cannot occur. When high-swing signalling is indicated, a request for a differential clock is ignored and raised as a mode error. A change of width or edge throws away any half-built pixel and holds the valid strobe low while the capture path refills.

Top module: `pixcap_dualedge`

## Requirements
- R1: The effective width bit selects narrow mode at 0 and wide mode at 1. The effective edge bit selects the rising edge at 1 and the falling edge at 0. Outside the blanking windows of R8 and R10, `pix_vld` is high on every rising edge in both widths, one strobe per pixel.
- R2: Wide mode with rising edge: the pixel output after rising edge k+1 equals `bus_d` as it stood at rising edge k.
- R3: Wide mode with falling edge: the pixel output after rising edge k+1 equals `bus_d` at the falling edge that follows rising edge k.
- R4: Narrow mode with rising primary edge: output bits [11:0] come from `bus_d[11:0]` at rising edge k. Bits [23:12] come from `bus_d[11:0]` at the next falling edge. The joined word appears after rising edge k+1.
- R5: Narrow mode with falling primary edge: bits [11:0] come from `bus_d[11:0]` at the falling edge before rising edge k. Bits [23:12] come from `bus_d[11:0]` at rising edge k. The joined word appears after rising edge k+1.
- R6: `hsync_o`, `vsync_o` and `de_o` carry the qualifier inputs sampled with the primary (or only) half of the same pixel that appears on `pix_o`.
- R7: With `cfg_from_reg` at 1, width, edge and clock-mode come from the `reg_*` inputs and the `pin_*` inputs have no effect. With `cfg_from_reg` at 0, the roles swap.
- R8: If the effective width or edge differs at rising edge k from its value at edge k-1, `pix_vld` is low after edges k and k+1. It returns high after edge k+2 if the configuration is then stable.
- R9: When `high_swing` is 1, `diff_clk_active` is 0 after the next rising edge, whatever clock mode is requested. `mode_err` is 1 after the next rising edge exactly when `high_swing` is 1 and a differential clock is requested. With `high_swing` at 0, `diff_clk_active` follows the request.
- R10: A synchronous active-high `rst` clears `pix_o`, `pix_vld`, the qualifier outputs, `diff_clk_active` and `mode_err` on the next rising edge. After `rst` falls, `pix_vld` stays low for one more edge and rises on the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges capture, the rising edge drives the outputs |
| rst | input | 1 | Synchronous active-high reset |
| bus_d | input | 24 | Pixel data bus; only [11:0] is used in narrow mode |
| hsync_i | input | 1 | Horizontal sync in |
| vsync_i | input | 1 | Vertical sync in |
| de_i | input | 1 | Data enable in |
| cfg_from_reg | input | 1 | 1: configuration from register fields, 0: from pins |
| pin_wide | input | 1 | Strap: 1 wide, 0 narrow |
| pin_rise | input | 1 | Strap: 1 rising, 0 falling (primary) edge |
| pin_diff | input | 1 | Strap: differential clock request |
| reg_wide | input | 1 | Register field: 1 wide, 0 narrow |
| reg_rise | input | 1 | Register field: 1 rising, 0 falling (primary) edge |
| reg_diff | input | 1 | Register field: differential clock request |
| high_swing | input | 1 | High-swing signalling indicated |
| pix_o | output | 24 | Assembled pixel |
| pix_vld | output | 1 | Pixel valid strobe |
| hsync_o | output | 1 | Horizontal sync aligned with pix_o |
| vsync_o | output | 1 | Vertical sync aligned with pix_o |
| de_o | output | 1 | Data enable aligned with pix_o |
| diff_clk_active | output | 1 | Effective clock mode: 1 differential, 0 single-ended |
| mode_err | output | 1 | Differential clock requested while in high-swing mode |

## Verification
Every pixel result is due after the rising edge that follows the capture edge of its last half. The bench keeps a count of rising edges. It drives the falling-edge value 3 ns after each rising edge and the next rising-edge value 8 ns after it. Expected words are rebuilt from that count and the mode's offset rule, and outputs are sampled 1 ns after a rising edge. Configuration, swing and reset changes are applied just after an edge. Their effects are checked one edge later, or two to three edges later for the valid blanking window.

// File: rtl/pixcap_dualedge.sv
module pixcap_dualedge #(
  parameter int HALF_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*HALF_W-1:0] bus_d,
  input  logic                hsync_i,
  input  logic                vsync_i,
  input  logic                de_i,
  input  logic                cfg_from_reg,
  input  logic                pin_wide,
  input  logic                pin_rise,
  input  logic                pin_diff,
  input  logic                reg_wide,
  input  logic                reg_rise,
  input  logic                reg_diff,
  input  logic                high_swing,
  output logic [2*HALF_W-1:0] pix_o,
  output logic                pix_vld,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic                de_o,
  output logic                diff_clk_active,
  output logic                mode_err
);
  localparam int PIX_W = 2 * HALF_W;
  localparam int CAP_W = PIX_W + 3;

  logic wide, rise, diff_req;
  assign wide     = cfg_from_reg ? reg_wide : pin_wide;
  assign rise     = cfg_from_reg ? reg_rise : pin_rise;
  assign diff_req = cfg_from_reg ? reg_diff : pin_diff;

  logic [CAP_W-1:0] bus_w;
  assign bus_w = {hsync_i, vsync_i, de_i, bus_d};

  logic [CAP_W-1:0] pos_r, neg_r, neg_h;
  always_ff @(posedge clk) pos_r <= bus_w;
  always_ff @(negedge clk) neg_r <= bus_w;
  always_ff @(posedge clk) neg_h <= neg_r;

  logic [1:0] cfg_q;
  logic       settle;
  logic       chg;
  assign chg = ({wide, rise} != cfg_q);

  logic [CAP_W-1:0] nxt;
  always_comb begin
    unique case ({wide, rise})
      2'b11:   nxt = pos_r;
      2'b10:   nxt = neg_r;
      2'b01:   nxt = {pos_r[CAP_W-1:PIX_W], neg_r[HALF_W-1:0], pos_r[HALF_W-1:0]};
      default: nxt = {neg_h[CAP_W-1:PIX_W], pos_r[HALF_W-1:0], neg_h[HALF_W-1:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    cfg_q <= {wide, rise};
    if (rst) begin
      settle          <= 1'b1;
      pix_o           <= '0;
      pix_vld         <= 1'b0;
      {hsync_o, vsync_o, de_o} <= 3'b000;
      diff_clk_active <= 1'b0;
      mode_err        <= 1'b0;
    end else begin
      settle          <= chg;
      pix_o           <= nxt[PIX_W-1:0];
      pix_vld         <= !(chg || settle);
      {hsync_o, vsync_o, de_o} <= nxt[CAP_W-1:PIX_W];
      diff_clk_active <= diff_req && !high_swing;
      mode_err        <= diff_req && high_swing;
    end
  end
endmodule

module pixcap_dualedge_chk #(
  parameter int HALF_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic [2*HALF_W-1:0] bus_d,
  input logic                cfg_from_reg,
  input logic                pin_wide,
  input logic                pin_rise,
  input logic                pin_diff,
  input logic                reg_wide,
  input logic                reg_rise,
  input logic                reg_diff,
  input logic                high_swing,
  input logic [2*HALF_W-1:0] pix_o,
  input logic                pix_vld,
  input logic                diff_clk_active,
  input logic                mode_err
);
  logic [1:0] eff;
  logic       dreq;
  assign eff  = cfg_from_reg ? {reg_wide, reg_rise} : {pin_wide, pin_rise};
  assign dreq = cfg_from_reg ? reg_diff : pin_diff;

  AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (!pix_vld && pix_o == '0)); // R10
  AST_CFG_BLANK: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && eff != $past(eff)) |=> (!pix_vld ##1 !pix_vld)); // R8
  AST_HS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    high_swing |=> !diff_clk_active); // R9
  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (high_swing && dreq) |=> mode_err); // R9
  AST_WIDE_RISE: assert property (@(posedge clk) disable iff (rst)
    (pix_vld && $past(eff) == 2'b11 && $past(eff, 2) == 2'b11) |-> pix_o == $past(bus_d, 2)); // R2
endmodule

bind pixcap_dualedge pixcap_dualedge_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst(rst), .bus_d(bus_d), .cfg_from_reg(cfg_from_reg),
  .pin_wide(pin_wide), .pin_rise(pin_rise), .pin_diff(pin_diff),
  .reg_wide(reg_wide), .reg_rise(reg_rise), .reg_diff(reg_diff),
  .high_swing(high_swing), .pix_o(pix_o), .pix_vld(pix_vld),
  .diff_clk_active(diff_clk_active), .mode_err(mode_err)
);

// File: tb/sim_pixcap_dualedge.sv
module sim_pixcap_dualedge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] bus_d;
  logic hsync_i, vsync_i, de_i;
  logic cfg_from_reg = 1'b0;
  logic pin_wide = 1'b1, pin_rise = 1'b1, pin_diff = 1'b0;
  logic reg_wide = 1'b1, reg_rise = 1'b1, reg_diff = 1'b0;
  logic high_swing = 1'b0;
  logic [23:0] pix_o;
  logic pix_vld, hsync_o, vsync_o, de_o, diff_clk_active, mode_err;

  int total = 0;
  int bad = 0;
  int rk = 0;

  always #5 clk = ~clk;

  pixcap_dualedge u0 (
    .clk(clk), .rst(rst), .bus_d(bus_d), .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i),
    .cfg_from_reg(cfg_from_reg), .pin_wide(pin_wide), .pin_rise(pin_rise), .pin_diff(pin_diff),
    .reg_wide(reg_wide), .reg_rise(reg_rise), .reg_diff(reg_diff), .high_swing(high_swing),
    .pix_o(pix_o), .pix_vld(pix_vld), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .diff_clk_active(diff_clk_active), .mode_err(mode_err)
  );

  function automatic logic [26:0] pat(int k, bit fall);
    logic [23:0] d;
    logic [2:0] q;
    d = 24'(k * 40503 + (fall ? 369601 : 0));
    q = {k[1] ^ fall, k[2], k[0] ^ k[3] ^ fall};
    return {q, d};
  endfunction

  task automatic put(logic [26:0] v);
    {hsync_i, vsync_i, de_i, bus_d} = v;
  endtask

  initial begin
    put(pat(1, 1'b0));
    forever begin
      @(posedge clk);
      rk = rk + 1;
      #3 put(pat(rk, 1'b1));
      #5 put(pat(rk + 1, 1'b0));
    end
  end

  function automatic logic [26:0] expect_at(int idx, logic w, logic r);
    logic [26:0] a, b, p;
    case ({w, r})
      2'b11: return pat(idx, 1'b0);
      2'b10: return pat(idx, 1'b1);
      2'b01: begin
        a = pat(idx, 1'b0); b = pat(idx, 1'b1);
        return {a[26:24], b[11:0], a[11:0]};
      end
      default: begin
        a = pat(idx, 1'b0); p = pat(idx - 1, 1'b1);
        return {p[26:24], a[11:0], p[11:0]};
      end
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sample();
    @(posedge clk);
    #1;
  endtask

  task automatic set_pins(logic w, logic r);
    @(posedge clk);
    #3;
    pin_wide = w;
    pin_rise = r;
  endtask

  task automatic stream_check(string req, logic w, logic r, int n);
    logic [26:0] e;
    for (int i = 0; i < n; i++) begin
      sample();
      e = expect_at(rk - 1, w, r);
      chk(req, {8'd0, pix_o}, {8'd0, e[23:0]});
      chk("R6", {29'd0, hsync_o, vsync_o, de_o}, {29'd0, e[26:24]});
      chk("R1", {31'd0, pix_vld}, 32'd1);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R10", {8'd0, pix_o}, 32'd0);
    chk("R10", {31'd0, pix_vld}, 32'd0);
    chk("R10", {30'd0, diff_clk_active, mode_err}, 32'd0);
    #2 rst = 1'b0;
    sample();
    chk("R10", {31'd0, pix_vld}, 32'd0);
    sample();
    chk("R10", {31'd0, pix_vld}, 32'd1);
  endtask

  task automatic t_mode(string req, logic w, logic r);
    set_pins(w, r);
    repeat (3) @(posedge clk);
    stream_check(req, w, r, 6);
  endtask

  task automatic t_source();
    @(posedge clk);
    #3;
    reg_wide = 1'b1; reg_rise = 1'b0;
    pin_wide = 1'b0; pin_rise = 1'b1;
    cfg_from_reg = 1'b1;
    repeat (3) @(posedge clk);
    stream_check("R7", 1'b1, 1'b0, 3);
    @(posedge clk);
    #3;
    pin_wide = 1'b1; pin_rise = 1'b1;
    stream_check("R7", 1'b1, 1'b0, 3);
    @(posedge clk);
    #3 cfg_from_reg = 1'b0;
    repeat (3) @(posedge clk);
    stream_check("R7", 1'b1, 1'b1, 2);
  endtask

  task automatic t_blank();
    logic [26:0] e;
    sample();
    chk("R8", {31'd0, pix_vld}, 32'd1);
    #2;
    pin_wide = 1'b0; pin_rise = 1'b1;
    sample();
    chk("R8", {31'd0, pix_vld}, 32'd0);
    sample();
    chk("R8", {31'd0, pix_vld}, 32'd0);
    sample();
    chk("R8", {31'd0, pix_vld}, 32'd1);
    e = expect_at(rk - 1, 1'b0, 1'b1);
    chk("R8", {8'd0, pix_o}, {8'd0, e[23:0]});
  endtask

  task automatic t_swing();
    @(posedge clk);
    #3;
    high_swing = 1'b1; pin_diff = 1'b1;
    sample();
    chk("R9", {31'd0, diff_clk_active}, 32'd0);
    chk("R9", {31'd0, mode_err}, 32'd1);
    #2 high_swing = 1'b0;
    sample();
    chk("R9", {31'd0, diff_clk_active}, 32'd1);
    chk("R9", {31'd0, mode_err}, 32'd0);
    #2 pin_diff = 1'b0;
    sample();
    chk("R9", {30'd0, diff_clk_active, mode_err}, 32'd0);
    chk("R9", {31'd0, pix_vld}, 32'd1);
  endtask

  task automatic t_reset_mid();
    @(posedge clk);
    #3 rst = 1'b1;
    sample();
    chk("R10", {8'd0, pix_o}, 32'd0);
    chk("R10", {31'd0, pix_vld}, 32'd0);
    #2 rst = 1'b0;
    sample();
    chk("R10", {31'd0, pix_vld}, 32'd0);
    sample();
    chk("R10", {31'd0, pix_vld}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_mode("R2", 1'b1, 1'b1);
    t_mode("R3", 1'b1, 1'b0);
    t_mode("R4", 1'b0, 1'b1);
    t_mode("R5", 1'b0, 1'b0);
    t_mode("R1", 1'b1, 1'b1);
    t_source();
    t_blank();
    t_swing();
    t_mode("R5", 1'b0, 1'b0);
    t_reset_mid();
    stream_check("R5", 1'b0, 1'b0, 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule